// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This block performs double-width shifts on 16-bit or 32-bit operands. A destination operand is moved left or right by a count, and the bit positions it vacates are filled from a second, fill operand. The fill operand only supplies bits; nothing writes it back. Along with the new destination value, the block produces a fresh set of arithmetic status flags (carry, parity, auxiliary carry, zero, sign, overflow). A count that is zero after masking, or too large for the 16-bit form, leaves both the value and the flags exactly as they came in.

The shift network and flag logic are combinational. The outcome is captured into an output register when `start` is high. A two-state controller (`ST_IDLE`, `ST_CAPT`) reports when a fresh result is present. Its transitions are: IDLE→CAPT on `start`, IDLE→IDLE without `start`, CAPT→CAPT on a back-to-back `start`, and CAPT→IDLE without `start`. `res_valid` is high exactly while the controller is in `ST_CAPT`. The surrounding pipeline supplies operands and the incoming flags, and takes the result one cycle later.

Top module: `fsh_funnel_unit`

## Requirements
- R1: On a rising clock edge with `start` high, `result` and `flags_out` load the computed outcome and `res_valid` is high for the following cycle. With `start` low, `res_valid` goes low and `result` and `flags_out` hold. After reset, all three outputs are zero.
- R2: The count is reduced to its low 5 bits. A reduced count of zero makes the operation a no-op: `result` equals `dst` and `flags_out` equals `flags_in`. The flag bus bit order is 0 carry, 1 parity, 2 auxiliary carry, 3 zero, 4 sign, 5 overflow.
- R3: With `size32` low (16-bit form), a reduced count from 16 to 31 is also a no-op for both the value and the flags.
- R4: A right shift (`shift_left` low) by n moves the operand-width destination toward bit 0. The n vacated upper bits are filled from bits n-1..0 of the fill operand, in order.
- R5: A left shift by n moves the destination toward its MSB. The n vacated lower bits are filled from the n highest bits of the fill operand, in order.
- R6: Carry is destination bit n-1 for a right shift, and destination bit W-n for a left shift, where W is 16 or 32.
- R7: For n equal to 1, overflow is the destination MSB XOR fill bit 0 on a right shift, and the destination MSB XOR the destination bit just below it on a left shift.
- R8: For any effective n other than 1, overflow is cleared.
- R9: On an effective shift, zero is set when the W-bit result is all zeros, and sign is the W-bit result's MSB. Parity is set when the result's low byte has an even number of ones.
- R10: Auxiliary carry is set on every effective shift, in both sizes.
- R11: In 16-bit form, `result[31:16]` always equals `dst[31:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the computed outcome on this edge |
| shift_left | input | 1 | 1 = left double shift, 0 = right double shift |
| size32 | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| count | input | 8 | Shift count; only the low 5 bits are used |
| dst | input | 32 | Destination operand |
| src | input | 32 | Fill operand |
| flags_in | input | 6 | Current flags, returned unchanged on a no-op |
| result | output | 32 | New destination value |
| flags_out | output | 6 | Updated flags |
| res_valid | output | 1 | High for the cycle after a capture |

## Verification
Every result (`result`, `flags_out` and `res_valid`) is due one clock edge after the edge that sees `start`, since exactly one register stands between inputs and outputs. The bench raises `start` and presents operands on a falling edge, lets one rising edge pass, and compares all three outputs at the next falling edge. It then drops `start` and checks that the outputs stay put. Rules that tie the captured value to the previous cycle's inputs are written as one-cycle implications in the bound checker.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = DATA_W / 2;
    localparam int COUNT_IN_W = 8;
    localparam int CNT_W      = $clog2(DATA_W);
    localparam int FLAG_W     = 6;
    localparam int NUM_SIZES  = 2;

    // bit 0 carry ... bit 5 overflow
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zer;
        logic aux;
        logic par;
        logic cry;
    } fsh_flags_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CAPT = 1'b1
    } fsh_state_e;

    function automatic logic even_ones8(input logic [7:0] b);
        return ~(^b);
    endfunction
endpackage

// File: rtl/fsh_count_gate.sv
module fsh_count_gate
    import fsh_pkg::*;
#(
    parameter int IN_W  = COUNT_IN_W,
    parameter int CW    = CNT_W,
    parameter int HALFW = HALF_W
) (
    input  logic [IN_W-1:0] count,
    input  logic            size32,
    output logic [CW-1:0]   cnt,
    output logic            active,
    output logic            single
);
    localparam int HI_W = IN_W - CW;

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = count[IN_W-1:CW];

    always_comb begin
        cnt    = count[CW-1:0];
        single = (cnt == CW'(1));
        if (cnt == '0) begin
            active = 1'b0;
        end else if (!size32 && (int'(cnt) >= HALFW)) begin
            active = 1'b0;
        end else begin
            active = 1'b1;
        end
    end
endmodule

// File: rtl/fsh_lane.sv
module fsh_lane #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic [W-1:0]  dst,
    input  logic [W-1:0]  src,
    input  logic [CW-1:0] cnt,
    input  logic          shift_left,
    output logic [W-1:0]  res,
    output logic          carry,
    output logic          ovf1
);
    logic [2*W-1:0] right_cat;
    logic [2*W-1:0] left_cat;
    logic [W:0]     right_cy;
    logic [W:0]     left_cy;

    always_comb begin
        right_cat = {src, dst} >> cnt;
        left_cat  = {dst, src} << cnt;
        right_cy  = {dst, 1'b0} >> cnt;
        left_cy   = {1'b0, dst} << cnt;
        if (shift_left) begin
            res   = left_cat[2*W-1:W];
            carry = left_cy[W];
            ovf1  = dst[W-1] ^ dst[W-2];
        end else begin
            res   = right_cat[W-1:0];
            carry = right_cy[0];
            ovf1  = dst[W-1] ^ src[0];
        end
    end
endmodule

// File: rtl/fsh_flag_gen.sv
module fsh_flag_gen
    import fsh_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int HW = HALF_W
) (
    input  logic [DW-1:0] res,
    input  logic          size32,
    input  logic          carry,
    input  logic          ovf1,
    input  logic          single,
    input  logic          active,
    input  fsh_flags_t    flags_in,
    output fsh_flags_t    flags_out
);
    always_comb begin
        if (!active) begin
            flags_out = flags_in;
        end else begin
            flags_out.cry = carry;
            flags_out.par = even_ones8(res[7:0]);
            flags_out.aux = 1'b1;
            flags_out.zer = size32 ? (res == '0) : (res[HW-1:0] == '0);
            flags_out.sgn = size32 ? res[DW-1] : res[HW-1];
            flags_out.ovf = single ? ovf1 : 1'b0;
        end
    end
endmodule

// File: rtl/fsh_funnel_unit.sv
module fsh_funnel_unit
    import fsh_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int IW  = COUNT_IN_W,
    parameter int CW  = CNT_W,
    parameter int FW  = FLAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          shift_left,
    input  logic          size32,
    input  logic [IW-1:0] count,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  logic [FW-1:0] flags_in,
    output logic [DW-1:0] result,
    output logic [FW-1:0] flags_out,
    output logic          res_valid
);
    localparam int HW = DW / 2;

    logic [CW-1:0] cnt;
    logic          active;
    logic          single;
    logic [DW-1:0] lane_res [NUM_SIZES];
    logic          lane_cy  [NUM_SIZES];
    logic          lane_ov  [NUM_SIZES];
    logic [DW-1:0] merged;
    logic [DW-1:0] next_res;
    fsh_flags_t    next_flags;
    fsh_state_e    state_q, state_d;

    fsh_count_gate #(.IN_W(IW), .CW(CW), .HALFW(HW)) u_gate (
        .count (count),
        .size32(size32),
        .cnt   (cnt),
        .active(active),
        .single(single)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_SIZES; g++) begin : g_lane
            localparam int LW = HW << g;
            logic [LW-1:0] lres;
            fsh_lane #(.W(LW), .CW(CW)) u_lane (
                .dst       (dst[LW-1:0]),
                .src       (src[LW-1:0]),
                .cnt       (cnt),
                .shift_left(shift_left),
                .res       (lres),
                .carry     (lane_cy[g]),
                .ovf1      (lane_ov[g])
            );
            assign lane_res[g] = DW'(lres);
        end
    endgenerate

    always_comb begin
        if (size32) begin
            merged = lane_res[1];
        end else begin
            merged = {dst[DW-1:HW], lane_res[0][HW-1:0]};
        end
        next_res = active ? merged : dst;
    end

    fsh_flag_gen #(.DW(DW), .HW(HW)) u_flags (
        .res      (merged),
        .size32   (size32),
        .carry    (size32 ? lane_cy[1] : lane_cy[0]),
        .ovf1     (size32 ? lane_ov[1] : lane_ov[0]),
        .single   (single),
        .active   (active),
        .flags_in (fsh_flags_t'(flags_in)),
        .flags_out(next_flags)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_CAPT : ST_IDLE;
            ST_CAPT: state_d = start ? ST_CAPT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            flags_out <= '0;
        end else if (start) begin
            result    <= next_res;
            flags_out <= next_flags;
        end
    end

    assign res_valid = (state_q == ST_CAPT);
endmodule

// File: rtl/fsh_funnel_checker.sv
module fsh_funnel_checker #(
    parameter int DW = 32,
    parameter int IW = 8,
    parameter int CW = 5,
    parameter int FW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          size32,
    input logic [IW-1:0] count,
    input logic [DW-1:0] dst,
    input logic [FW-1:0] flags_in,
    input logic [DW-1:0] result,
    input logic [FW-1:0] flags_out,
    input logic          res_valid
);
    localparam int HW = DW / 2;
    logic [CW-1:0] m;
    assign m = count[CW-1:0];

    a_r1_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> res_valid);
    a_r1_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !res_valid);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(flags_out)));
    a_r2_zero_count_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (start && m == '0) |=> (result == $past(dst) && flags_out == $past(flags_in)));
    a_r3_half_big_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !size32 && int'(m) >= HW) |=> (result == $past(dst) && flags_out == $past(flags_in)));
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (start && int'(m) > 1 && (size32 || int'(m) < HW)) |=> !flags_out[5]);
    a_r10_aux_set: assert property (@(posedge clk) disable iff (!rst_n)
        (start && m != '0 && (size32 || int'(m) < HW)) |=> flags_out[2]);
    a_r11_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !size32) |=> (result[DW-1:HW] == $past(dst[DW-1:HW])));
endmodule

bind fsh_funnel_unit fsh_funnel_checker #(.DW(DW), .IW(IW), .CW(CW), .FW(FW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .size32   (size32),
    .count    (count),
    .dst      (dst),
    .flags_in (flags_in),
    .result   (result),
    .flags_out(flags_out),
    .res_valid(res_valid)
);

// File: tb/fsh_funnel_unit_test.sv
module fsh_funnel_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        shift_left = 1'b0;
    logic        size32 = 1'b0;
    logic [7:0]  count = '0;
    logic [31:0] dst = '0;
    logic [31:0] src = '0;
    logic [5:0]  flags_in = '0;
    logic [31:0] result;
    logic [5:0]  flags_out;
    logic        res_valid;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fsh_funnel_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .shift_left(shift_left),
        .size32(size32), .count(count), .dst(dst), .src(src),
        .flags_in(flags_in), .result(result), .flags_out(flags_out),
        .res_valid(res_valid)
    );

    // {left, size32, count[7:0], dst, src, flags_in, exp_result, exp_flags}
    localparam int VW = 1 + 1 + 8 + 32 + 32 + 6 + 32 + 6;
    localparam logic [VW-1:0] VECS [8] = '{
        {1'b0, 1'b1, 8'd4,  32'h0000_00F0, 32'h0000_0001, 6'h00, 32'h1000_000F, 6'h06},
        {1'b1, 1'b1, 8'd1,  32'h8000_0001, 32'hC000_0000, 6'h00, 32'h0000_0003, 6'h27},
        {1'b0, 1'b0, 8'd1,  32'hABCD_0001, 32'h0000_0000, 6'h00, 32'hABCD_0000, 6'h0F},
        {1'b0, 1'b0, 8'd16, 32'h1234_5678, 32'hFFFF_FFFF, 6'h2A, 32'h1234_5678, 6'h2A},
        {1'b1, 1'b1, 8'h20, 32'hDEAD_BEEF, 32'h1111_1111, 6'h15, 32'hDEAD_BEEF, 6'h15},
        {1'b1, 1'b0, 8'd15, 32'h0000_0003, 32'h0000_8000, 6'h00, 32'h0000_C000, 6'h17},
        {1'b0, 1'b1, 8'd31, 32'h8000_0000, 32'hFFFF_FFFF, 6'h00, 32'hFFFF_FFFF, 6'h16},
        {1'b0, 1'b1, 8'd1,  32'h8000_0000, 32'h0000_0000, 6'h00, 32'h4000_0000, 6'h26}
    };

    function automatic void model(input logic l, input logic s32, input logic [7:0] c8,
                                  input logic [31:0] d, input logic [31:0] s,
                                  input logic [5:0] fi,
                                  output logic [31:0] r, output logic [5:0] fo);
        int w = s32 ? 32 : 16;
        int n = int'(c8 & 8'h1F);
        int ones = 0;
        logic [31:0] v = d;
        if (n == 0 || (!s32 && n >= 16)) begin
            r = d; fo = fi;
            return;
        end
        for (int i = 0; i < w; i++) begin
            if (l) v[i] = (i >= n) ? d[i-n] : s[w-n+i];
            else   v[i] = (i + n < w) ? d[i+n] : s[i+n-w];
        end
        r = v;
        for (int i = 0; i < 8; i++) ones += int'(v[i]);
        fo[0] = l ? d[w-n] : d[n-1];
        fo[1] = (ones % 2) == 0;
        fo[2] = 1'b1;
        fo[3] = s32 ? (v == 32'h0) : (v[15:0] == 16'h0);
        fo[4] = v[w-1];
        fo[5] = (n == 1) ? (l ? (d[w-1] ^ d[w-2]) : (d[w-1] ^ s[0])) : 1'b0;
    endfunction

    task automatic apply(input logic l, input logic s32, input logic [7:0] c8,
                         input logic [31:0] d, input logic [31:0] s, input logic [5:0] fi,
                         input logic [31:0] er, input logic [5:0] ef, input string tag);
        @(negedge clk);
        shift_left = l; size32 = s32; count = c8; dst = d; src = s; flags_in = fi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_vec++;
        if (result !== er || flags_out !== ef || res_valid !== 1'b1) begin
            n_bad++;
            $display("FAIL %s: l=%0d s32=%0d cnt=%0d dst=%h src=%h got res=%h fl=%h v=%0d exp res=%h fl=%h v=1",
                     tag, l, s32, c8, d, s, result, flags_out, res_valid, er, ef);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pat_d [3];
        logic [31:0] pat_s [3];
        logic [31:0] er;
        logic [5:0]  ef;
        logic [31:0] held_r;
        logic [5:0]  held_f;
        pat_d = '{32'h8421_F0A5, 32'h7FFF_0001, 32'h0000_0000};
        pat_s = '{32'h1357_9BDF, 32'hFFFF_FFFE, 32'h8000_0001};

        repeat (3) @(negedge clk);
        n_vec++;
        if (result !== 32'h0 || flags_out !== 6'h0 || res_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got res=%h fl=%h v=%0d exp 0 0 0", result, flags_out, res_valid);
        end
        rst_n = 1'b1;

        // directed table: R4 R5 R6 R7 R8 R9 R10 R11 R2 R3
        for (int k = 0; k < 8; k++) begin
            logic [VW-1:0] e = VECS[k];
            apply(e[117], e[116], e[115:108], e[107:76], e[75:44], e[43:38],
                  e[37:6], e[5:0], "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 table");
        end

        // R1 hold: inputs change without start
        held_r = result; held_f = flags_out;
        @(negedge clk);
        dst = ~dst; count = 8'd3; flags_in = ~flags_in;
        @(negedge clk);
        n_vec++;
        if (result !== held_r || flags_out !== held_f || res_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 hold: got res=%h fl=%h v=%0d exp res=%h fl=%h v=0",
                     result, flags_out, res_valid, held_r, held_f);
        end

        // full sweep of counts, both directions and sizes
        for (int p = 0; p < 3; p++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int sz = 0; sz < 2; sz++) begin
                    for (int c = 0; c < 32; c++) begin
                        model(dir[0], sz[0], 8'(c), pat_d[p], pat_s[p], 6'h2D, er, ef);
                        apply(dir[0], sz[0], 8'(c), pat_d[p], pat_s[p], 6'h2D, er, ef,
                              "R4 R5 R6 R7 R8 R9 R10 R3 R2 sweep");
                    end
                end
            end
        end

        // R2 masking: upper count bits ignored (count 0xE3 acts as 3)
        model(1'b0, 1'b1, 8'd3, 32'hF00F_1234, 32'h0000_0005, 6'h00, er, ef);
        apply(1'b0, 1'b1, 8'hE3, 32'hF00F_1234, 32'h0000_0005, 6'h00, er, ef, "R2 mask");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule